// File: doc/BRIEF.md
# Microprogram Sequencer with Encoded Jump Types

This block is the next-address unit of a microcoded controller. It holds the micro-PC and keeps a control-store word aligned with it. Each word has three fields: a datapath control field, a three-bit jump-type code and an absolute target address. Every clock the sequencer picks the next micro-PC from one of four sources. These are the incremented micro-PC, the current micro-PC (to hold in place), the absolute target in the word, or an entry point found by reducing the six-bit macro opcode to an op-group.

The control store is read synchronously. It is addressed with the next micro-PC, so the word for a step is present in the same cycle as that step's micro-PC. Each word stores only a short jump code, not a complete next state. Because of this, the opcode and the busy and zero status bits never widen the control-store address. A small test microprogram is built into the table so the sequencer can run on its own. It contains a fetch sequence, several op-group bodies, and words that use the two reserved codes.

Top module: `useq_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the micro-PC is 0 (the first fetch step) and the control output shows the word at address 0.
- R2: Jump code 0 (next) moves the micro-PC to micro-PC+1, whatever busy, zero and opcode are.
- R3: Jump code 1 (spin) keeps the micro-PC unchanged while busy is 1 and moves to micro-PC+1 when busy is 0.
- R4: Jump code 2 (fetch) loads the absolute address field of the current word.
- R5: Jump code 3 (dispatch) loads the entry point of the op-group of the current opcode. The entry points are: arithmetic 4, load 7, branch-if-zero 11, branch-if-nonzero 14, jump 17, unknown 21.
- R6: Jump code 4 loads the absolute address when zero is 1 and moves to micro-PC+1 otherwise.
- R7: Jump code 5 moves to micro-PC+1 when zero is 1 and loads the absolute address otherwise.
- R8: The unused codes 6 and 7 behave exactly like code 0.
- R9: In every cycle the control output is the control field of the word at the current micro-PC. In the test program that field is bit 16 set, bits 5:0 equal to the address, and all other bits 0.
- R10: The op-group map is: opcode 0x00 and opcodes 0x08 to 0x0F go to arithmetic, 0x23 to load, 0x04 to branch-if-zero, 0x05 to branch-if-nonzero, 0x02 to jump, and every other opcode to unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Macro opcode used by dispatch |
| busy | input | 1 | Memory busy status, tested by spin |
| zero | input | 1 | Zero status, tested by the two conditional codes |
| upc | output | 6 | Current micro-PC |
| ctrl | output | 17 | Datapath control field of the current word |

## Verification
The hardest situation to reach is a spin step held for several cycles in a row. Only the fetch wait and the load wait use spin, and reaching the load wait needs a dispatch with the load opcode followed by two plain steps. The stimulus drives busy high with a high probability and draws opcodes from a list weighted toward defined op-groups. As a result, dispatch regularly reaches every group, and spins held over many cycles occur often. A reset asserted in the middle of the run checks that the sequencer returns to the fetch start from an arbitrary step.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [2:0] {
      JT_NEXT  = 3'd0,
      JT_SPIN  = 3'd1,
      JT_FETCH = 3'd2,
      JT_DISP  = 3'd3,
      JT_FEQZ  = 3'd4,
      JT_FNEZ  = 3'd5,
      JT_RSV6  = 3'd6,
      JT_RSV7  = 3'd7
   } jump_e;

   typedef enum logic [2:0] {
      GRP_ALU  = 3'd0,
      GRP_LOAD = 3'd1,
      GRP_BEQZ = 3'd2,
      GRP_BNEZ = 3'd3,
      GRP_JUMP = 3'd4,
      GRP_ILL  = 3'd5
   } group_e;

   localparam int JT_W = 3;

   // entry points of the test microprogram
   localparam int ENT_FETCH = 0;
   localparam int ENT_ALU   = 4;
   localparam int ENT_LOAD  = 7;
   localparam int ENT_BEQZ  = 11;
   localparam int ENT_BNEZ  = 14;
   localparam int ENT_JUMP  = 17;
   localparam int ENT_ILL   = 21;
   localparam int PROG_LEN  = 22;

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UPC_W  = 6,
   parameter int CTRL_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [UPC_W-1:0]  rd_addr,
   output logic [CTRL_W-1:0] ctrl,
   output logic [JT_W-1:0]   jt,
   output logic [UPC_W-1:0]  abs_addr
);

   localparam int DEPTH  = 1 << UPC_W;
   localparam int WORD_W = CTRL_W + JT_W + UPC_W;

   function automatic logic [WORD_W-1:0] entry(input int a);
      logic [CTRL_W-1:0] c;
      jump_e             j;
      logic [UPC_W-1:0]  t;
      c = '0;
      c[UPC_W-1:0] = UPC_W'(a);
      c[CTRL_W-1]  = 1'b1;
      t = UPC_W'(ENT_FETCH);
      case (a)
         0:  j = JT_NEXT;
         1:  j = JT_SPIN;
         2:  j = JT_NEXT;
         3:  j = JT_DISP;
         4:  j = JT_NEXT;
         5:  j = JT_NEXT;
         6:  j = JT_FETCH;
         7:  j = JT_NEXT;
         8:  j = JT_NEXT;
         9:  j = JT_SPIN;
         10: j = JT_FETCH;
         11: j = JT_FNEZ;
         12: j = JT_NEXT;
         13: j = JT_FETCH;
         14: j = JT_FEQZ;
         15: j = JT_NEXT;
         16: j = JT_FETCH;
         17: j = JT_NEXT;
         18: j = JT_RSV6;
         19: j = JT_RSV7;
         20: j = JT_FETCH;
         default: j = JT_FETCH;
      endcase
      return {c, j, t};
   endfunction

   logic [WORD_W-1:0] rom [DEPTH];
   logic [WORD_W-1:0] word_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = entry(g);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= rom[ENT_FETCH];
      else        word_q <= rom[rd_addr];
   end

   assign {ctrl, jt, abs_addr} = word_q;

endmodule

// File: rtl/useq_opmap.sv
module useq_opmap
   import useq_pkg::*;
#(
   parameter int OP_W  = 6,
   parameter int UPC_W = 6
) (
   input  logic [OP_W-1:0]  opcode,
   output logic [UPC_W-1:0] disp_addr
);

   group_e grp;

   always_comb begin
      if (opcode == OP_W'(6'h00) || opcode[OP_W-1:3] == 3'b001) grp = GRP_ALU;
      else if (opcode == OP_W'(6'h23))                           grp = GRP_LOAD;
      else if (opcode == OP_W'(6'h04))                           grp = GRP_BEQZ;
      else if (opcode == OP_W'(6'h05))                           grp = GRP_BNEZ;
      else if (opcode == OP_W'(6'h02))                           grp = GRP_JUMP;
      else                                                       grp = GRP_ILL;
   end

   always_comb begin
      case (grp)
         GRP_ALU:  disp_addr = UPC_W'(ENT_ALU);
         GRP_LOAD: disp_addr = UPC_W'(ENT_LOAD);
         GRP_BEQZ: disp_addr = UPC_W'(ENT_BEQZ);
         GRP_BNEZ: disp_addr = UPC_W'(ENT_BNEZ);
         GRP_JUMP: disp_addr = UPC_W'(ENT_JUMP);
         default:  disp_addr = UPC_W'(ENT_ILL);
      endcase
   end

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
   import useq_pkg::*;
#(
   parameter int UPC_W = 6
) (
   input  logic [UPC_W-1:0] upc,
   input  logic [JT_W-1:0]  jt,
   input  logic [UPC_W-1:0] abs_addr,
   input  logic [UPC_W-1:0] disp_addr,
   input  logic             busy,
   input  logic             zero,
   output logic [UPC_W-1:0] nxt
);

   logic [UPC_W-1:0] inc;
   jump_e            code;

   assign inc  = upc + 1'b1;
   assign code = jump_e'(jt);

   always_comb begin
      case (code)
         JT_SPIN:  nxt = busy ? upc : inc;
         JT_FETCH: nxt = abs_addr;
         JT_DISP:  nxt = disp_addr;
         JT_FEQZ:  nxt = zero ? abs_addr : inc;
         JT_FNEZ:  nxt = zero ? inc : abs_addr;
         default:  nxt = inc;
      endcase
   end

endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int OP_W   = 6,
   parameter int UPC_W  = 6,
   parameter int CTRL_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   opcode,
   input  logic              busy,
   input  logic              zero,
   output logic [UPC_W-1:0]  upc,
   output logic [CTRL_W-1:0] ctrl
);

   localparam int DEPTH = 1 << UPC_W;

   if (DEPTH < PROG_LEN) begin : g_bad_upc
      $error("UPC_W too small for the test microprogram");
   end
   if (OP_W != 6) begin : g_bad_op
      $error("op-group map expects a 6-bit opcode");
   end
   if (CTRL_W <= UPC_W) begin : g_bad_ctrl
      $error("CTRL_W must exceed UPC_W");
   end

   logic [UPC_W-1:0] upc_q;
   logic [UPC_W-1:0] nxt;
   logic [UPC_W-1:0] disp_addr;
   logic [UPC_W-1:0] cur_abs;
   logic [JT_W-1:0]  cur_jt;

   useq_store #(.UPC_W(UPC_W), .CTRL_W(CTRL_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (nxt),
      .ctrl     (ctrl),
      .jt       (cur_jt),
      .abs_addr (cur_abs)
   );

   useq_opmap #(.OP_W(OP_W), .UPC_W(UPC_W)) u_opmap (
      .opcode    (opcode),
      .disp_addr (disp_addr)
   );

   useq_nextaddr #(.UPC_W(UPC_W)) u_next (
      .upc       (upc_q),
      .jt        (cur_jt),
      .abs_addr  (cur_abs),
      .disp_addr (disp_addr),
      .busy      (busy),
      .zero      (zero),
      .nxt       (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc_q <= UPC_W'(ENT_FETCH);
      else        upc_q <= nxt;
   end

   assign upc = upc_q;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
   import useq_pkg::*;
#(
   parameter int UPC_W  = 6,
   parameter int CTRL_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              zero,
   input logic [UPC_W-1:0]  upc,
   input logic [CTRL_W-1:0] ctrl,
   input logic [JT_W-1:0]   jt,
   input logic [UPC_W-1:0]  abs_addr
);

   AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> upc == UPC_W'(ENT_FETCH)); // R1

   AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_NEXT) |=> upc == UPC_W'($past(upc) + 1'b1)); // R2

   AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_SPIN && busy) |=> $stable(upc)); // R3

   AST_SPIN_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_SPIN && !busy) |=> upc == UPC_W'($past(upc) + 1'b1)); // R3

   AST_FETCH_ABS: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_FETCH) |=> upc == $past(abs_addr)); // R4

   AST_FEQZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_FEQZ && zero) |=> upc == $past(abs_addr)); // R6

   AST_FNEZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_FNEZ && !zero) |=> upc == $past(abs_addr)); // R7

   AST_RSV_AS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (jt == JT_RSV6 || jt == JT_RSV7) |=> upc == UPC_W'($past(upc) + 1'b1)); // R8

   AST_CTRL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[UPC_W-1:0] == upc); // R9

endmodule

bind useq_top useq_chk #(.UPC_W(UPC_W), .CTRL_W(CTRL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .zero     (zero),
   .upc      (upc),
   .ctrl     (ctrl),
   .jt       (cur_jt),
   .abs_addr (cur_abs)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  opcode = 6'h00;
   logic        busy = 1'b0;
   logic        zero = 1'b0;
   logic [5:0]  upc;
   logic [16:0] ctrl;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   useq_top dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode),
      .busy(busy), .zero(zero), .upc(upc), .ctrl(ctrl)
   );

   // behavioural microprogram description: jump kind and target per address
   int    mjt  [64];
   int    mabs [64];
   int    m_upc = 0;
   string tag = "R1";

   initial begin
      for (int a = 0; a < 64; a++) begin mjt[a] = 2; mabs[a] = 0; end
      mjt[0]=0; mjt[1]=1; mjt[2]=0; mjt[3]=3;
      mjt[4]=0; mjt[5]=0; mjt[6]=2;
      mjt[7]=0; mjt[8]=0; mjt[9]=1; mjt[10]=2;
      mjt[11]=5; mjt[12]=0; mjt[13]=2;
      mjt[14]=4; mjt[15]=0; mjt[16]=2;
      mjt[17]=0; mjt[18]=6; mjt[19]=7; mjt[20]=2;
   end

   function automatic int group_entry(input int op);
      if (op == 0 || (op >= 8 && op <= 15)) return 4;
      if (op == 'h23) return 7;
      if (op == 4) return 11;
      if (op == 5) return 14;
      if (op == 2) return 17;
      return 21;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_upc = 0; tag = "R1";
      end else begin
         case (mjt[m_upc])
            1: begin tag = "R3";     m_upc = busy ? m_upc : m_upc + 1; end
            2: begin tag = "R4";     m_upc = mabs[m_upc]; end
            3: begin tag = "R5 R10"; m_upc = group_entry(int'(opcode)); end
            4: begin tag = "R6";     m_upc = zero ? mabs[m_upc] : m_upc + 1; end
            5: begin tag = "R7";     m_upc = zero ? m_upc + 1 : mabs[m_upc]; end
            6, 7: begin tag = "R8";  m_upc = m_upc + 1; end
            default: begin tag = "R2"; m_upc = m_upc + 1; end
         endcase
         m_upc = m_upc % 64;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic [16:0] exp_ctrl;
         exp_ctrl = 17'h10000 | 17'(m_upc);
         n_chk++;
         if (int'(upc) != m_upc) begin
            n_fail++;
            $display("FAIL %s upc actual=%0d expected=%0d", tag, upc, m_upc);
         end
         n_chk++;
         if (ctrl !== exp_ctrl) begin
            n_fail++;
            $display("FAIL R9 ctrl actual=%h expected=%h", ctrl, exp_ctrl);
         end
      end
   end

   int ops [10] = '{6'h00, 6'h08, 6'h0D, 6'h23, 6'h04, 6'h05, 6'h02, 6'h3F, 6'h11, 6'h23};

   task automatic drive(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         busy   = ($urandom % 3) != 0;
         zero   = ($urandom % 2) == 1;
         opcode = (($urandom % 4) == 0) ? 6'($urandom) : 6'(ops[$urandom % 10]);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;          // R1 checked by the per-cycle compare
      drive(2500);
      @(posedge clk); #1 rst_n = 1'b0;   // mid-run reset, R1
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      drive(2500);
      @(negedge clk); #1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule